// File: doc/BRIEF.md
# Raster Timer Interrupt Flag Unit

This block is the host-facing interrupt logic of a raster timer. The current horizontal and vertical beam positions arrive as inputs. The block compares them with two 9-bit compare values that the host loads one byte at a time. When the comparison selected by the host takes place, a sticky timer flag is raised. The host interrupt line is that flag ORed with an interrupt request coming from the cartridge.

The host clears the flag through its status register, either by reading it or by writing it. The flag is also cleared when the host turns both timer enables off. A status read returns the flag in the top bit, and the floating data-bus value in the other bits. A debug read returns the same value but leaves the flag as it is.

The flag is a two-state machine. In state FL_IDLE no interrupt from the timer is pending. In state FL_PEND the flag is set. Transition ARM goes from FL_IDLE to FL_PEND on a compare event. Transition ACK goes from FL_PEND to FL_IDLE on a clearing access, and it is taken only when no compare event occurs in the same cycle.

Top module: `raster_irq_unit`

## Requirements
- R1: A compare event raises the timer flag at the next clock edge. The flag shows on `irq_out` and in bit 7 of a status read, and it stays set until it is cleared.
- R2: The flag is cleared by a write to the status register (`reg_sel` = 5), whatever data is written. It is also cleared by a normal read of the status register (`rd_en` = 1, `dbg_rd` = 0, `reg_sel` = 5).
- R3: A write to the enable register (`reg_sel` = 0) with data bits 5:4 = 00 clears the flag. A write to the enable register with a nonzero value in bits 5:4 leaves the flag unchanged.
- R4: A read with `reg_sel` = 5 returns {flag, `open_bus[6:0]`} on `rd_data`. A read with any other select value returns `open_bus` unchanged.
- R5: `irq_out` is high whenever the timer flag is set or `cart_irq` is high.
- R6: Each compare value is 9 bits wide. For the horizontal value, `reg_sel` = 1 writes the low byte and `reg_sel` = 2 writes the high byte. For the vertical value, `reg_sel` = 3 writes the low byte and `reg_sel` = 4 writes the high byte. A high-byte write takes data bit 0 into bit 8 and keeps bits 7:0. A low-byte write replaces bits 7:0 and keeps bit 8.
- R7: A read with `dbg_rd` = 1 returns the same data as a normal read and does not clear the flag.
- R8: Bits 5:4 of the enable register select the compare mode:
  - 00: no events.
  - 01: match when `h_pos` equals the horizontal compare value.
  - 10: match when `v_pos` equals the vertical compare value and `h_pos` = 0.
  - 11: match when both positions equal their compare values.

  An event occurs only in the first cycle of a match, so an unchanged matching position does not raise the flag again.
- R9: When a compare event and a clearing access occur in the same cycle, the flag ends up set.
- R10: After reset the flag is clear, both compare values are 0, and the compare mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select for reads and writes |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| dbg_rd | input | 1 | Marks the current read as free of side effects |
| wr_data | input | 8 | Write data |
| open_bus | input | 8 | Floating data-bus value merged into reads |
| rd_data | output | 8 | Read data |
| h_pos | input | 9 | Current horizontal raster position |
| v_pos | input | 9 | Current vertical raster position |
| cart_irq | input | 1 | Interrupt request from the cartridge |
| irq_out | output | 1 | Host interrupt line |

## Verification
A compare event and an acknowledging access can fall in the same cycle, and the flag logic has to settle that clash. The bench provokes it by moving `h_pos` onto the horizontal compare value in the same cycle as a status write. It judges the result by checking that `irq_out` is high and that a later debug read still shows bit 7 set. The bench also provokes a disabling enable write together with a cartridge request. In that case it checks that `irq_out` stays high because of the cartridge request alone, while the debug status shows the timer flag clear.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
    typedef enum logic [2:0] {
        SEL_ENA  = 3'd0,
        SEL_HLO  = 3'd1,
        SEL_HHI  = 3'd2,
        SEL_VLO  = 3'd3,
        SEL_VHI  = 3'd4,
        SEL_STAT = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_H   = 2'b01,
        MODE_V   = 2'b10,
        MODE_HV  = 2'b11
    } cmp_mode_e;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/rirq_regs.sv
module rirq_regs
    import rirq_pkg::*;
#(
    parameter int POS_W  = 9,
    parameter int DATA_W = 8,
    parameter int MODE_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [POS_W-1:0]  h_cmp,
    output logic [POS_W-1:0]  v_cmp,
    output cmp_mode_e         mode
);
    localparam int HI_W = POS_W - DATA_W;

    logic [POS_W-1:0] cmp_q [2];

    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam reg_sel_e LO_SEL = (a == 0) ? SEL_HLO : SEL_VLO;
        localparam reg_sel_e HI_SEL = (a == 0) ? SEL_HHI : SEL_VHI;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q[a] <= '0;
            end else if (wr_en && sel == LO_SEL) begin
                cmp_q[a] <= {cmp_q[a][POS_W-1:DATA_W], wr_data};
            end else if (wr_en && sel == HI_SEL) begin
                cmp_q[a] <= {wr_data[HI_W-1:0], cmp_q[a][DATA_W-1:0]};
            end
        end

        assert_hi_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel == HI_SEL) |=> cmp_q[a][DATA_W-1:0] == $past(cmp_q[a][DATA_W-1:0]));
        assert_lo_keeps_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel == LO_SEL) |=> cmp_q[a][POS_W-1:DATA_W] == $past(cmp_q[a][POS_W-1:DATA_W]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_OFF;
        end else if (wr_en && sel == SEL_ENA) begin
            mode <= cmp_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
        end
    end

    assign h_cmp = cmp_q[0];
    assign v_cmp = cmp_q[1];
endmodule

// File: rtl/rirq_match.sv
module rirq_match
    import rirq_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmp_mode_e        mode,
    input  logic [POS_W-1:0] h_pos,
    input  logic [POS_W-1:0] v_pos,
    input  logic [POS_W-1:0] h_cmp,
    input  logic [POS_W-1:0] v_cmp,
    output logic             fire
);
    logic hit;
    logic hit_q;
    logic h_eq;
    logic v_eq;

    assign h_eq = (h_pos == h_cmp);
    assign v_eq = (v_pos == v_cmp);

    always_comb begin
        unique case (mode)
            MODE_OFF: hit = 1'b0;
            MODE_H:   hit = h_eq;
            MODE_V:   hit = v_eq && (h_pos == '0);
            MODE_HV:  hit = h_eq && v_eq;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    assign fire = hit && !hit_q;

    assert_single_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/rirq_flag.sv
module rirq_flag
    import rirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (set_evt) state_d = FL_PEND;
            FL_PEND: if (clr_req && !set_evt) state_d = FL_IDLE;
            default: state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FL_PEND);
    end

    assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !flag);
endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit
    import rirq_pkg::*;
#(
    parameter int POS_W  = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              dbg_rd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] open_bus,
    output logic [DATA_W-1:0] rd_data,
    input  logic [POS_W-1:0]  h_pos,
    input  logic [POS_W-1:0]  v_pos,
    input  logic              cart_irq,
    output logic              irq_out
);
    localparam int MODE_LSB = 4;
    localparam int FLAG_BIT = DATA_W - 1;

    reg_sel_e         sel;
    logic [POS_W-1:0] h_cmp;
    logic [POS_W-1:0] v_cmp;
    cmp_mode_e        mode;
    logic             fire;
    logic             flag;
    logic             stat_ack;
    logic             ena_off;
    logic             clr_req;

    assign sel = reg_sel_e'(reg_sel);

    rirq_regs #(.POS_W(POS_W), .DATA_W(DATA_W), .MODE_LSB(MODE_LSB)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .h_cmp   (h_cmp),
        .v_cmp   (v_cmp),
        .mode    (mode)
    );

    rirq_match #(.POS_W(POS_W)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .h_pos (h_pos),
        .v_pos (v_pos),
        .h_cmp (h_cmp),
        .v_cmp (v_cmp),
        .fire  (fire)
    );

    assign stat_ack = (sel == SEL_STAT) && (wr_en || (rd_en && !dbg_rd));
    assign ena_off  = wr_en && (sel == SEL_ENA) && (wr_data[MODE_LSB+1:MODE_LSB] == 2'b00);
    assign clr_req  = stat_ack || ena_off;

    rirq_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (fire),
        .clr_req (clr_req),
        .flag    (flag)
    );

    always_comb begin
        if (rd_en && sel == SEL_STAT) rd_data = {flag, open_bus[FLAG_BIT-1:0]};
        else                          rd_data = open_bus;
    end

    assign irq_out = flag || cart_irq;

    assert_dbg_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && rd_en && dbg_rd && !wr_en) |=> flag);
    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ENA && wr_data[MODE_LSB+1:MODE_LSB] == 2'b00 && !fire) |=> !irq_out || cart_irq);
endmodule

// File: tb/test_raster_irq_unit.sv
`timescale 1ns/100ps
module test_raster_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       dbg_rd = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] open_bus = 8'h5A;
    logic [7:0] rd_data;
    logic [8:0] h_pos = 9'h1FF;
    logic [8:0] v_pos = 9'h1FF;
    logic       cart_irq = 1'b0;
    logic       irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    raster_irq_unit i_raster_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .dbg_rd(dbg_rd), .wr_data(wr_data), .open_bus(open_bus), .rd_data(rd_data),
        .h_pos(h_pos), .v_pos(v_pos), .cart_irq(cart_irq), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; reg_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input logic dbg, output logic [7:0] d);
        rd_en = 1'b1; dbg_rd = dbg; reg_sel = s;
        #1 d = rd_data;
        tick();
        rd_en = 1'b0; dbg_rd = 1'b0;
    endtask

    task automatic pos(input logic [8:0] h, input logic [8:0] v);
        h_pos = h; v_pos = v;
        tick();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R10 irq after reset", irq_out, 0);
        rd(3'd5, 1'b1, d);
        chk("R10 flag after reset", d[7], 0);
        pos(9'h000, 9'h000);
        chk("R10 no event with zero compare and mode 00", irq_out, 0);
        pos(9'h1FF, 9'h1FF);
    endtask

    task automatic t_hmode();
        logic [7:0] d;
        wr(3'd1, 8'h23);
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h10);
        pos(9'h023, 9'h010);
        chk("R6 bit 8 must match", irq_out, 0);
        pos(9'h123, 9'h010);
        chk("R1 R8 H event raises irq", irq_out, 1);
        rd(3'd5, 1'b1, d);
        chk("R1 status bit 7", d[7], 1);
        wr(3'd5, 8'h00);
        chk("R2 status write clears", irq_out, 0);
        tick(); tick();
        chk("R8 no refire while held", irq_out, 0);
        pos(9'h1FF, 9'h010);
        wr(3'd2, 8'hFE);
        pos(9'h023, 9'h010);
        chk("R6 high write keeps low byte", irq_out, 1);
        wr(3'd5, 8'hFF);
        pos(9'h1FF, 9'h010);
        wr(3'd1, 8'h45);
        pos(9'h145, 9'h010);
        chk("R6 low write keeps bit 8", irq_out, 0);
        pos(9'h045, 9'h010);
        chk("R6 low write new value", irq_out, 1);
        wr(3'd5, 8'h00);
        pos(9'h1FF, 9'h1FF);
    endtask

    task automatic t_vmode();
        logic [7:0] d;
        wr(3'd3, 8'h40);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h20);
        pos(9'h005, 9'h040);
        chk("R8 V mode needs h=0", irq_out, 0);
        pos(9'h000, 9'h040);
        chk("R8 V mode event", irq_out, 1);
        open_bus = 8'hA5;
        rd(3'd5, 1'b0, d);
        chk("R4 status read value", d, 8'hA5);
        chk("R2 status read clears", irq_out, 0);
        rd(3'd1, 1'b0, d);
        chk("R4 other select reads open bus", d, 8'hA5);
        open_bus = 8'h5A;
        pos(9'h1FF, 9'h1FF);
    endtask

    task automatic t_hvmode();
        logic [7:0] d;
        wr(3'd1, 8'h30);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h07);
        wr(3'd4, 8'h01);
        wr(3'd0, 8'h30);
        pos(9'h030, 9'h008);
        chk("R8 HV needs V", irq_out, 0);
        pos(9'h030, 9'h107);
        chk("R8 HV event", irq_out, 1);
        wr(3'd0, 8'h10);
        chk("R3 nonzero enable keeps flag", irq_out, 1);
        wr(3'd0, 8'hCF);
        chk("R3 enable 00 clears", irq_out, 0);
        rd(3'd5, 1'b1, d);
        chk("R3 status after disable", d[7], 0);
        pos(9'h1FF, 9'h1FF);
    endtask

    task automatic t_dbg_cart();
        logic [7:0] d;
        wr(3'd1, 8'h11);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h10);
        pos(9'h011, 9'h000);
        rd(3'd5, 1'b1, d);
        chk("R7 debug read data", d, 8'hDA);
        rd(3'd5, 1'b1, d);
        chk("R7 flag kept after debug read", d[7], 1);
        chk("R7 irq kept", irq_out, 1);
        wr(3'd5, 8'h00);
        cart_irq = 1'b1;
        #1 chk("R5 cartridge irq alone", irq_out, 1);
        wr(3'd0, 8'h00);
        chk("R5 cart irq with disabled timer", irq_out, 1);
        rd(3'd5, 1'b1, d);
        chk("R5 timer flag clear", d[7], 0);
        cart_irq = 1'b0;
        #1 chk("R5 both low", irq_out, 0);
        pos(9'h1FF, 9'h1FF);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        wr(3'd0, 8'h10);
        h_pos = 9'h011; v_pos = 9'h000;
        wr(3'd5, 8'h00);
        chk("R9 set wins over status write", irq_out, 1);
        rd(3'd5, 1'b1, d);
        chk("R9 flag after clash", d[7], 1);
        wr(3'd5, 8'h00);
        chk("R2 later write clears", irq_out, 0);
        pos(9'h1FF, 9'h1FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_hmode();
        t_vmode();
        t_hvmode();
        t_dbg_cart();
        t_priority();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule